// File: doc/BRIEF.md
# Temperature Limit Interrupt Controller

This block watches a stream of finished temperature conversions. It compares each new reading against two programmable limit pairs. Each pair has a trip limit and a lower release (hysteresis) limit. From these comparisons it drives two outputs: an interrupt line and an active-low overtemperature shutdown line. The reading and all limits are two's complement words of `TW` bits. A 9-bit word has a 0.5 degree step and a 12-bit word has a 0.0625 degree step. For example, +25 degrees is 0x032 in 9-bit format and 0x190 in 12-bit format.

The interrupt line runs in one of two modes. In the repeating mode it fires again on every conversion while the reading stays hot. In the one-shot mode it fires once and then waits until the reading has cooled below its release limit. The shutdown line runs either in one-shot mode or as a level comparator with hysteresis. Two inputs release the latched events. A status-read strobe clears both latched flags. A clear-bit input releases the interrupt channel only. Limits are evaluated only on the conversion-done strobe.

Top module: `temp_limit_irq`

## Requirements
- R1: After reset `int_o` is inactive (low with the default `INT_ACT_HIGH=1`), `os_n` is 1 and `status` is 2'b00.
- R2: Limits are compared as signed values. Changes on `temp` or on the limits have no effect on any output unless `conv_done` is high in that cycle.
- R3: A reading trips a limit only when it is strictly greater than the limit. It releases only when it is strictly less than the release limit, so a reading equal to either one leaves the state unchanged.
- R4: In repeating mode (`int_mode`=0), a conversion above the hot limit raises `int_o` and `status[0]` in the next cycle. Both then stay raised until they are cleared.
- R5: In repeating mode, once the interrupt is cleared, the next conversion raises it again if the reading has not fallen below the hot release limit. A conversion below that release limit drops `int_o` and `status[0]` without any clear.
- R6: In one-shot mode (`int_mode`=1 for the interrupt line, `os_mode`=0 for the shutdown line), once an event has been cleared the output does not fire again until a conversion has fallen below the release limit and a later conversion exceeds the trip limit.
- R7: The shutdown channel uses the overtemperature limit pair. It shows an event by driving `os_n` low and setting `status[1]`.
- R8: In comparator mode (`os_mode`=1), `os_n` goes low on a conversion above the overtemperature limit. It returns high only on a conversion below the overtemperature release limit, and the clear inputs do not affect it. `status[1]` latches each conversion that finds the channel hot.
- R9: `stat_rd` clears both `status` bits and releases both latched outputs. `int_clr` clears only the interrupt channel and leaves `status[1]` and `os_n` unchanged.
- R10: When a clear and a conversion fall in the same cycle, the clear wins and the flag is 0 after that edge. The channel's hot/cool state still follows the conversion.
- R11: Mode encodings: `int_mode` 0 = repeating, 1 = one-shot; `os_mode` 0 = one-shot, 1 = comparator. A mode change takes effect on the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: `temp` holds a new reading |
| temp | input | TW | Signed temperature reading |
| hot_lim | input | TW | Interrupt trip limit (signed) |
| hot_hyst | input | TW | Interrupt release limit (signed) |
| ot_lim | input | TW | Shutdown trip limit (signed) |
| ot_hyst | input | TW | Shutdown release limit (signed) |
| int_mode | input | 1 | 0 repeating, 1 one-shot |
| os_mode | input | 1 | 0 one-shot, 1 comparator |
| stat_rd | input | 1 | Status-read strobe, clears both channels |
| int_clr | input | 1 | Clear bit for the interrupt channel |
| int_o | output | 1 | Interrupt line, polarity set by `INT_ACT_HIGH` |
| os_n | output | 1 | Active-low shutdown line |
| status | output | 2 | Latched flags: [0] interrupt, [1] shutdown |

## Verification
The bench drives readings exactly equal to each trip limit and each release limit. A design that compared with >= or <= would fire or release one step too early. A test case places a positive reading above a negative limit, so an unsigned compare would miss the trip. The bench issues clear strobes in the same cycle as conversions, and with the reading held between the two limits. A design that let the conversion win, or that re-armed the one-shot channel without a cool-down, would show an extra or a missing interrupt. The bench also switches modes mid-run and holds `conv_done` low while the reading changes, which catches outputs that follow `temp` continuously.

// File: rtl/tli_pkg.sv
package tli_pkg;

   typedef enum logic [1:0] {
      TLI_REPEAT  = 2'd0,
      TLI_ONESHOT = 2'd1,
      TLI_LEVEL   = 2'd2
   } tli_mode_e;

   localparam int TLI_NCH = 2;

endpackage

// File: rtl/tli_cmp.sv
module tli_cmp #(
   parameter int TW = 12
) (
   input  logic [TW-1:0] reading,
   input  logic [TW-1:0] trip,
   input  logic [TW-1:0] release_lvl,
   output logic          above,
   output logic          below
);

   always_comb begin
      above = $signed(reading) > $signed(trip);
      below = $signed(reading) < $signed(release_lvl);
   end

endmodule

// File: rtl/tli_chan.sv
module tli_chan
   import tli_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      conv,
   input  logic      clr,
   input  tli_mode_e mode,
   input  logic      above,
   input  logic      below,
   output logic      act,
   output logic      flag
);

   logic hot, hot_nx, flag_nx, fresh;

   always_comb begin
      hot_nx = above | (hot & ~below);
      fresh  = above & ~hot;
      flag_nx = flag;
      if (conv) begin
         unique case (mode)
            TLI_REPEAT:  flag_nx = hot_nx;
            TLI_ONESHOT: flag_nx = flag | fresh;
            TLI_LEVEL:   flag_nx = flag | hot_nx;
            default:     flag_nx = flag;
         endcase
      end
      if (clr) flag_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hot  <= 1'b0;
         flag <= 1'b0;
      end else begin
         flag <= flag_nx;
         if (conv) hot <= hot_nx;
      end
   end

   assign act = (mode == TLI_LEVEL) ? hot : flag;

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !conv && !clr |=> $stable(flag) && $stable(hot));

   // R10
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);

   // R5
   cool_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv && below |=> !hot);

   // R3
   equal_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv && !above && !hot |=> !hot);

   // R6
   oneshot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv && mode == TLI_ONESHOT && hot && !flag |=> !flag);

endmodule

// File: rtl/temp_limit_irq.sv
module temp_limit_irq
   import tli_pkg::*;
#(
   parameter int TW           = 12,
   parameter bit INT_ACT_HIGH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conv_done,
   input  logic [TW-1:0] temp,
   input  logic [TW-1:0] hot_lim,
   input  logic [TW-1:0] hot_hyst,
   input  logic [TW-1:0] ot_lim,
   input  logic [TW-1:0] ot_hyst,
   input  logic          int_mode,
   input  logic          os_mode,
   input  logic          stat_rd,
   input  logic          int_clr,
   output logic          int_o,
   output logic          os_n,
   output logic [1:0]    status
);

   localparam int CH_INT = 0;
   localparam int CH_OS  = 1;

   if (TW < 4 || TW > 32) begin : g_bad_tw
      $error("temp_limit_irq: TW must lie in 4..32");
   end

   tli_mode_e                 ch_mode [TLI_NCH];
   logic [TLI_NCH-1:0]        ch_clr, ch_above, ch_below, ch_act, ch_flag;

   assign ch_mode[CH_INT] = int_mode ? TLI_ONESHOT : TLI_REPEAT;
   assign ch_mode[CH_OS]  = os_mode  ? TLI_LEVEL   : TLI_ONESHOT;
   assign ch_clr[CH_INT]  = stat_rd | int_clr;
   assign ch_clr[CH_OS]   = stat_rd;

   for (genvar g = 0; g < TLI_NCH; g++) begin : g_ch
      tli_cmp #(.TW(TW)) u_cmp (
         .reading     (temp),
         .trip        ((g == CH_INT) ? hot_lim  : ot_lim),
         .release_lvl ((g == CH_INT) ? hot_hyst : ot_hyst),
         .above       (ch_above[g]),
         .below       (ch_below[g])
      );
      tli_chan u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .conv  (conv_done),
         .clr   (ch_clr[g]),
         .mode  (ch_mode[g]),
         .above (ch_above[g]),
         .below (ch_below[g]),
         .act   (ch_act[g]),
         .flag  (ch_flag[g])
      );
   end

   if (INT_ACT_HIGH) begin : g_int_hi
      assign int_o = ch_act[CH_INT];
   end else begin : g_int_lo
      assign int_o = ~ch_act[CH_INT];
   end

   assign os_n   = ~ch_act[CH_OS];
   assign status = ch_flag;

   // R8
   level_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done && os_mode && ch_above[CH_OS] |=> !os_n);

   // R8
   level_clear_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
      os_mode && !conv_done && stat_rd && $past(os_mode) |=> $stable(os_n));

   // R9
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> status == 2'b00);

   // R9
   intclr_keeps_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_clr && !stat_rd && !conv_done |=> $stable(status[CH_OS]));

endmodule

// File: tb/tb_temp_limit_irq.sv
`timescale 1ns/1ps
module tb_temp_limit_irq;

   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_done = 1'b0;
   logic [TW-1:0] temp = '0;
   logic [TW-1:0] hot_lim, hot_hyst, ot_lim, ot_hyst;
   logic          int_mode = 1'b0, os_mode = 1'b0;
   logic          stat_rd = 1'b0, int_clr = 1'b0;
   logic          int_o, os_n;
   logic [1:0]    status;

   int hl = 400, hh = 320, ol = 800, oh = 720;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // model state: index 0 interrupt channel, 1 shutdown channel
   bit m_hot [2];
   bit m_flag[2];

   always #2 clk = ~clk;

   temp_limit_irq #(.TW(TW)) dut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp(temp),
      .hot_lim(hot_lim), .hot_hyst(hot_hyst), .ot_lim(ot_lim), .ot_hyst(ot_hyst),
      .int_mode(int_mode), .os_mode(os_mode), .stat_rd(stat_rd), .int_clr(int_clr),
      .int_o(int_o), .os_n(os_n), .status(status));

   always_comb begin
      hot_lim  = hl[TW-1:0];
      hot_hyst = hh[TW-1:0];
      ot_lim   = ol[TW-1:0];
      ot_hyst  = oh[TW-1:0];
   end

   task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {int_o,os_n,status} got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [3:0] model_out();
      logic os_act;
      os_act = os_mode ? m_hot[1] : m_flag[1];
      return {m_flag[0], ~os_act, m_flag[1], m_flag[0]};
   endfunction

   // mode codes: 0 repeat, 1 one-shot, 2 level
   task automatic model_ch(input int ch, input int md, input bit cv, input int t,
                           input int lim, input int hy, input bit clr);
      bit ab, be, hn;
      ab = t > lim;
      be = t < hy;
      hn = ab || (m_hot[ch] && !be);
      if (cv) begin
         case (md)
            0: m_flag[ch] = hn;
            1: m_flag[ch] = m_flag[ch] || (ab && !m_hot[ch]);
            default: m_flag[ch] = m_flag[ch] || hn;
         endcase
         m_hot[ch] = hn;
      end
      if (clr) m_flag[ch] = 1'b0;
   endtask

   // drive one cycle from a negedge, then compare at the next negedge
   task automatic step(input bit cv, input int t, input bit rd = 0, input bit ic = 0);
      conv_done = cv;
      temp      = t[TW-1:0];
      stat_rd   = rd;
      int_clr   = ic;
      model_ch(0, int_mode ? 1 : 0, cv, t, hl, hh, rd || ic);
      model_ch(1, os_mode ? 2 : 1, cv, t, ol, oh, rd);
      @(negedge clk);
      check(cur_req, {int_o, os_n, status}, model_out());
      conv_done = 1'b0;
      stat_rd   = 1'b0;
      int_clr   = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      m_hot  = '{0, 0};
      m_flag = '{0, 0};
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {int_o, os_n, status}, 4'b0100);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {int_o, os_n, status}, 4'b0100);

      // R4 / R11 repeating interrupt
      cur_req = "R4";
      step(1, 416);
      check("R4", {int_o, os_n, status}, 4'b1101);
      step(0, 0); step(0, 0);
      // R2 reading changes with no strobe
      cur_req = "R2";
      step(0, 100); step(0, 900);
      check("R2", {int_o, os_n, status}, 4'b1101);

      // R5 clear then re-fire while still hot
      cur_req = "R5";
      step(0, 0, 1);
      check("R5", {int_o, os_n, status}, 4'b0100);
      step(1, 336);
      check("R5", {int_o, os_n, status}, 4'b1101);
      step(0, 0, 0, 1);
      // R3 reading equal to release limit keeps it hot
      cur_req = "R3";
      step(1, 320);
      check("R3", {int_o, os_n, status}, 4'b1101);
      cur_req = "R5";
      step(1, 319);
      check("R5", {int_o, os_n, status}, 4'b0100);
      cur_req = "R3";
      step(1, 400);
      check("R3", {int_o, os_n, status}, 4'b0100);

      // R6 one-shot interrupt
      cur_req = "R6";
      int_mode = 1'b1;
      step(1, 416);
      step(0, 0, 1);
      step(1, 416);
      step(1, 336);
      check("R6", {int_o, os_n, status}, 4'b0100);
      step(1, 256);
      step(1, 416);
      check("R6", {int_o, os_n, status}, 4'b1101);
      step(0, 0, 1);

      // R7 one-shot shutdown, R9 clear routing
      cur_req = "R7";
      step(1, 816);
      check("R7", {int_o, os_n, status}, 4'b0010);
      cur_req = "R9";
      step(0, 0, 0, 1);
      check("R9", {int_o, os_n, status}, 4'b0010);
      step(0, 0, 1);
      check("R9", {int_o, os_n, status}, 4'b0100);
      cur_req = "R7";
      step(1, 816);
      step(1, 704);
      step(1, 816);
      check("R7", {int_o, os_n, status}, 4'b0010);
      step(0, 0, 1);

      // R8 comparator shutdown
      cur_req = "R8";
      os_mode = 1'b1;
      step(1, 816);
      step(0, 0, 1);
      check("R8", {int_o, os_n, status}, 4'b0000);
      step(1, 720);
      step(1, 719);
      check("R8", {int_o, os_n, status}, 4'b0110);
      step(1, 800);
      step(1, 801);
      check("R8", {int_o, os_n, status}, 4'b0010);
      step(1, 100, 1);

      // R10 clear coinciding with conversion
      cur_req = "R10";
      int_mode = 1'b0;
      os_mode  = 1'b0;
      step(1, 500, 1);
      check("R10", {int_o, os_n, status}, 4'b0100);
      step(1, 500);
      check("R10", {int_o, os_n, status}, 4'b1101);
      step(1, 100, 1);

      // R2 signed compare against negative limits
      cur_req = "R2";
      hl = -80; hh = -160;
      step(1, 16);
      check("R2", {int_o, os_n, status}, 4'b1101);
      step(1, -200);
      check("R2", {int_o, os_n, status}, 4'b0100);

      // R11 mode switch mid-run
      cur_req = "R11";
      int_mode = 1'b1;
      step(1, 16); step(0, 0, 1); step(1, 20);
      int_mode = 1'b0;
      step(1, 20);
      check("R11", {int_o, os_n, status}, 4'b1101);
      repeat (4) step(0, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule